// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Function Muxing and Edge Interrupts

This block controls a port of eight pads. Software reaches it through a small register bus: a 3-bit address, a write strobe, write data, and read data that follows the address with no clock delay. It sets each pin as a GPIO input or output, or gives the pin to an alternate peripheral. The block also drives each pad's output level and enable, and passes through a per-pin pull-enable bit to the pad cell.

Every pad input goes through a two-flop synchronizer. The synchronized level is readable, and it feeds an edge detector. The edge each pin reacts to, rising or falling, is set per pin. A detected edge sets a sticky flag. Software clears a flag by writing a one to it. A single interrupt line is high whenever an enabled flag is set. All state resets to zero, so every pin comes out of reset as a GPIO input with no interrupt.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every register reads zero, `pad_oe` and `pad_out` are zero and `irq` is low.
- R2: For a pin whose function bit is 0, `pad_oe` equals that pin's bit in the direction register (address 0; 1 = output, 0 = input).
- R3: For a pin whose function bit is 0, `pad_out` equals that pin's bit in the output register (address 1).
- R4: The input register (address 2) reads the pad level sampled two clock edges earlier.
- R5: For a pin whose bit in the function register (address 3) is 1, `pad_out` and `pad_oe` follow `alt_out` and `alt_oe` for that pin.
- R6: A pin's flag bit (address 6) is set on the third clock edge after its pad makes a rising transition if its edge-select bit (address 4) is 0, or a falling transition if that bit is 1.
- R7: Writing to the flag register clears each flag bit written as 1 and leaves bits written as 0 unchanged. Flags never clear otherwise.
- R8: If a flag clear and a new edge on the same pin land on the same clock edge, the flag stays set.
- R9: `irq` is high exactly when some flag bit and the matching bit of the enable register (address 5) are both 1.
- R10: Writes to address 2 have no effect.
- R11: `pad_pull_en` equals the pull register (address 7).
- R12: Reading any address returns the current contents of that register on `bus_rdata` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of addressed register |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables |
| pad_pull_en | output | 8 | Pull-resistor enables to pad cells |
| alt_out | input | 8 | Alternate peripheral output levels |
| alt_oe | input | 8 | Alternate peripheral output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The pads are driven through alternating patterns, 0x55 then 0xAA then back. With mixed edge selects, this separates pins that should flag on a rising edge from pins that should flag on a falling edge, and it catches an inverted polarity or a swapped bit. Flags are cleared with partial masks and with all-zero writes to tell W1C apart from plain overwrite. One clear is timed to land on the same edge as a fresh transition, which tests that set wins over clear. Function routing is tried with a split mask and with alternate data that differs from the GPIO data, so a mux stuck on either source shows at the pads. Partial interrupt enables confirm that masking works per bit.

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_pull_en,
  input  logic [W-1:0]  alt_out,
  input  logic [W-1:0]  alt_oe,
  output logic          irq
);
  localparam logic [AW-1:0] A_DIR  = AW'(0);
  localparam logic [AW-1:0] A_OUT  = AW'(1);
  localparam logic [AW-1:0] A_IN   = AW'(2);
  localparam logic [AW-1:0] A_FSEL = AW'(3);
  localparam logic [AW-1:0] A_EDGE = AW'(4);
  localparam logic [AW-1:0] A_IEN  = AW'(5);
  localparam logic [AW-1:0] A_FLAG = AW'(6);
  localparam logic [AW-1:0] A_PULL = AW'(7);

  logic [W-1:0] dir_q, out_q, fsel_q, edge_q, ien_q, flag_q, pull_q;
  logic [W-1:0] sync1_q, sync2_q, prev_q;
  logic [W-1:0] rise, fall, hit, clr;

  assign rise = sync2_q & ~prev_q;
  assign fall = ~sync2_q & prev_q;
  assign hit  = (rise & ~edge_q) | (fall & edge_q);
  assign clr  = (bus_wr && bus_addr == A_FLAG) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      fsel_q <= '0;
      edge_q <= '0;
      ien_q  <= '0;
      pull_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_DIR:   dir_q  <= bus_wdata;
        A_OUT:   out_q  <= bus_wdata;
        A_FSEL:  fsel_q <= bus_wdata;
        A_EDGE:  edge_q <= bus_wdata;
        A_IEN:   ien_q  <= bus_wdata;
        A_PULL:  pull_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr) | hit;
  end

  always_comb begin
    case (bus_addr)
      A_DIR:   bus_rdata = dir_q;
      A_OUT:   bus_rdata = out_q;
      A_IN:    bus_rdata = sync2_q;
      A_FSEL:  bus_rdata = fsel_q;
      A_EDGE:  bus_rdata = edge_q;
      A_IEN:   bus_rdata = ien_q;
      A_FLAG:  bus_rdata = flag_q;
      default: bus_rdata = pull_q;
    endcase
  end

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pin
      assign pad_out[i] = fsel_q[i] ? alt_out[i] : out_q[i];
      assign pad_oe[i]  = fsel_q[i] ? alt_oe[i]  : dir_q[i];
    end
  endgenerate

  assign pad_pull_en = pull_q;
  assign irq         = |(flag_q & ien_q);
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  pad_in,
  input logic [W-1:0]  pad_oe,
  input logic          irq,
  input logic [W-1:0]  dir_q,
  input logic [W-1:0]  fsel_q,
  input logic [W-1:0]  ien_q,
  input logic [W-1:0]  flag_q,
  input logic [W-1:0]  in_q
);
  localparam logic [AW-1:0] A_FLAG = AW'(6);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= 2'd0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  p_oe_gpio_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fsel_q == '0) |-> (pad_oe == dir_q));

  p_in_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2) |-> (in_q == $past(pad_in, 2)));

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_FLAG) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .pad_in(pad_in), .pad_oe(pad_oe), .irq(irq), .dir_q(dir_q),
  .fsel_q(fsel_q), .ien_q(ien_q), .flag_q(flag_q), .in_q(sync2_q)
);

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = 0;
  logic [7:0] pad_out, pad_oe, pad_pull_en;
  logic [7:0] alt_out = 0, alt_oe = 0;
  logic       irq;

  int checks = 0, errors = 0;
  bit done = 0;

  gpio_port_ctrl u_gpio_port_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
    .alt_out(alt_out), .alt_oe(alt_oe), .irq(irq)
  );

  always #4 clk = ~clk;

  // behavioural model
  int m_reg [8];
  int hist [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) m_reg[k] = 0;
      hist = {0, 0, 0, 0};
    end else begin
      int hitm, clrm;
      hist.push_front(int'(pad_in));
      void'(hist.pop_back());
      hitm = 0;
      for (int b = 0; b < 8; b++) begin
        int now_b, old_b;
        now_b = (hist[2] >> b) & 1;
        old_b = (hist[3] >> b) & 1;
        if (((m_reg[4] >> b) & 1) == 0 && now_b == 1 && old_b == 0) hitm |= (1 << b);
        if (((m_reg[4] >> b) & 1) == 1 && now_b == 0 && old_b == 1) hitm |= (1 << b);
      end
      clrm = (bus_wr && bus_addr == 6) ? int'(bus_wdata) : 0;
      m_reg[6] = ((m_reg[6] & ~clrm) | hitm) & 8'hFF;
      if (bus_wr && bus_addr != 2 && bus_addr != 6) m_reg[bus_addr] = int'(bus_wdata);
    end
  end

  function automatic string tag_of(int a);
    case (a)
      0: return "R2";  1: return "R3";  2: return "R4";  3: return "R5";
      4: return "R6";  5: return "R9";  6: return "R7";  default: return "R11";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always begin
    @(posedge clk);
    #2;
    if (!done) begin
      int e_out, e_oe, e_rd;
      e_out = 0; e_oe = 0;
      for (int b = 0; b < 8; b++) begin
        if ((m_reg[3] >> b) & 1) begin
          e_out |= int'(alt_out[b]) << b;
          e_oe  |= int'(alt_oe[b]) << b;
        end else begin
          e_out |= ((m_reg[1] >> b) & 1) << b;
          e_oe  |= ((m_reg[0] >> b) & 1) << b;
        end
      end
      e_rd = (bus_addr == 2) ? hist[1] : m_reg[bus_addr];
      check("R3/R5 pad_out", int'(pad_out), e_out);
      check("R2/R5 pad_oe", int'(pad_oe), e_oe);
      check("R11 pull", int'(pad_pull_en), m_reg[7]);
      check("R9 irq", int'(irq), int'((m_reg[6] & m_reg[5]) != 0));
      check({"R12 read ", tag_of(int'(bus_addr))}, int'(bus_rdata), e_rd);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_wr = 1; bus_addr = 3'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic sweep();
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      bus_addr = 3'(a);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      bus_addr = 3'(a);
      #1;
      check("R1 reset reg", int'(bus_rdata), 0);
    end
    check("R1 reset oe", int'(pad_oe), 0);
    check("R1 reset out", int'(pad_out), 0);
    check("R1 reset irq", int'(irq), 0);

    // R2 R3 R11 GPIO drive
    wr(0, 8'hA5); wr(1, 8'h3C); wr(7, 8'h0F);
    sweep();

    // R4 R6 edges, mixed selects
    wr(4, 8'h0F); wr(5, 8'hFF);
    @(negedge clk); pad_in = 8'h55; bus_addr = 2;
    idle(4);
    @(negedge clk); pad_in = 8'hAA;
    idle(4);
    @(negedge clk); bus_addr = 6;
    #1;
    // rise on 0x55 hits upper bits 4,6; falls from 0x55 to 0xAA hit bits 0,2; rise 0xAA upper 5,7
    check("R6 flags", int'(bus_rdata), 8'hF5);
    sweep();

    // R7 W1C and zero write
    wr(6, 8'h0F);
    @(negedge clk); bus_addr = 6; #1;
    check("R7 partial clear", int'(bus_rdata), 8'hF0);
    wr(6, 8'h00);
    @(negedge clk); bus_addr = 6; #1;
    check("R7 zero write", int'(bus_rdata), 8'hF0);
    // R9 masking
    wr(5, 8'h0F);
    @(negedge clk); #1;
    check("R9 masked irq", int'(irq), 0);
    wr(5, 8'h10);
    @(negedge clk); #1;
    check("R9 enabled irq", int'(irq), 1);
    wr(6, 8'hFF);
    @(negedge clk); bus_addr = 6; #1;
    check("R7 full clear", int'(bus_rdata), 0);

    // R8 clear coincides with edge: pin 1 falling (select 0x0F), pad 0xAA->0x88
    @(negedge clk); pad_in = 8'h88;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1; bus_addr = 6; bus_wdata = 8'h02;
    @(negedge clk);
    bus_wr = 0; #1;
    check("R8 set wins", int'(bus_rdata) & 2, 2);

    // R10 write to input register ignored
    wr(2, 8'h5A);
    @(negedge clk); bus_addr = 2; #1;
    check("R10 input unchanged", int'(bus_rdata), 8'h88);

    // R5 alternate function routing
    alt_out = 8'hC3; alt_oe = 8'h99;
    wr(3, 8'hF0);
    @(negedge clk); #1;
    check("R5 alt out", int'(pad_out), 8'hCC);
    check("R5 alt oe", int'(pad_oe), 8'h95);
    @(negedge clk); alt_out = 8'h3C; alt_oe = 8'h66;
    sweep();
    wr(3, 8'h00);
    @(negedge clk); pad_in = 8'h00;
    idle(5);
    sweep();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule